// File: doc/BRIEF.md
# Double-Buffered Frame Copy Coordinator

This block sits between a renderer and a display scan-out engine that reads from one of two frame buffers in memory. The scan-out engine stays parked on one buffer while freshly rendered pixels are copied into the other. When a copy request arrives with a source address and a total byte count, the block first halves the byte count until one share fits a single copy engine. It then hands out shares one engine at a time until enough bytes are covered or it runs out of engines. It issues a descriptor (destination, source, length and a two-level burst loop count) to every engine it claimed.

Each copy engine reports completion with a one-cycle done pulse. The block only moves the scan-out engine to the freshly written buffer after every claimed engine has reported. This keeps a buffer from being shown while part of it is still being written. A request that cannot fit across all engines, or that carries a negative length, is refused with an error pulse. A request that arrives while a copy is still outstanding is dropped.

Top module: `fb_swap_copier`

## Requirements
- R1: After reset, park_idx is 0, and busy, req_err, swap_strobe and every ch_start bit are 0.
- R2: The copy destination base is FB_BASE + FRAME_BYTES when park_idx is 0 at request time, and FB_BASE when park_idx is 1.
- R3: The per-engine length starts at req_len and is halved by integer division while it exceeds CHAN_MAX, which is BURST_BYTES × 65536.
- R4: Engines are claimed in index order starting at 0. Claiming stops at the first count n where n × length ≥ req_len, or at NCH. Engines 0..n-1 receive a one-cycle ch_start pulse in the same cycle, and the other bits stay 0.
- R5: Engine i receives destination = destination base + i × length and source = req_src + i × length. Unclaimed engines show length 0.
- R6: A request with bit LEN_W-1 set (a negative length) or with req_len > NCH × CHAN_MAX raises req_err for exactly one cycle, in the cycle after the request. No ch_start follows, and busy stays 0.
- R7: busy is 1 from the cycle after an accepted request until the swap. A request presented while busy is ignored, producing no ch_start and no req_err.
- R8: park_idx toggles, following park_idx = (park_idx + 1) mod 2, in the same clock edge that registers the last outstanding done pulse. swap_strobe is 1 for exactly that one following cycle. No toggle happens while any claimed engine is outstanding.
- R9: With bursts = length / BURST_BYTES: if bursts > 256, then ch_outer = bursts / 256 and ch_inner = bursts mod 256. Otherwise ch_outer = 0 and ch_inner = bursts.
- R10: Done pulses on unclaimed engines, or done pulses while idle, change neither park_idx nor swap_strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Copy request strobe |
| req_src | input | ADDR_W | Source base address of rendered pixels |
| req_len | input | LEN_W | Total byte count (MSB set means negative) |
| ch_done | input | NCH | Per-engine completion pulses |
| busy | output | 1 | A copy is being planned or is outstanding |
| req_err | output | 1 | One-cycle rejection pulse |
| ch_start | output | NCH | One-cycle start pulse per claimed engine |
| ch_dst | output | NCH×ADDR_W | Per-engine destination address |
| ch_src | output | NCH×ADDR_W | Per-engine source address |
| ch_len | output | NCH×LEN_W | Per-engine byte count |
| ch_outer | output | NCH×9 | Per-engine outer burst loop count |
| ch_inner | output | NCH×9 | Per-engine inner/residue burst loop count |
| park_idx | output | 1 | Buffer the scan-out engine is parked on |
| swap_strobe | output | 1 | One-cycle pulse when park_idx toggles |

## Verification
The bench targets lengths that sit exactly at CHAN_MAX, one byte above it, and at the full NCH × CHAN_MAX limit.

- One byte above CHAN_MAX forces a halving into three uneven-coverage engines, so a wrong stop rule shows up as a wrong ch_start mask or wrong offsets.
- Completion pulses arrive in rotated order, with a stray pulse on an unclaimed engine first. A design that swaps on the first or on any pulse flips park_idx too early.
- A request made while copies are outstanding must produce nothing. A design that accepts it re-clears the done flags and restarts the engines.
- Negative and one-over-limit lengths must raise only the error pulse.
- A destination chosen from the wrong parked index would write into the buffer on screen, and shows up as swapped ch_dst values on alternate copies.

// File: rtl/fbsc_pkg.sv
package fbsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PLAN,
        ST_ISSUE,
        ST_WAIT
    } ctl_state_e;

    typedef enum logic [1:0] {
        SP_IDLE,
        SP_HALVE,
        SP_ALLOC
    } split_phase_e;

    localparam int LOOP_RADIX = 256;

    typedef struct packed {
        logic [8:0] outer;
        logic [8:0] inner;
    } loop_cnt_t;

    // Two-level burst loop split of an 8-bit nested counter pair
    function automatic loop_cnt_t split_loops(input logic [31:0] bursts);
        loop_cnt_t r;
        if (bursts > 32'(LOOP_RADIX)) begin
            r.outer = 9'(bursts / 32'(LOOP_RADIX));
            r.inner = {1'b0, bursts[7:0]};
        end else begin
            r.outer = 9'd0;
            r.inner = bursts[8:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/fbsc_splitter.sv
module fbsc_splitter
    import fbsc_pkg::*;
#(
    parameter int LEN_W    = 32,
    parameter int NCH      = 4,
    parameter longint CHAN_MAX = 2097152,
    localparam int CNT_W   = $clog2(NCH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] total,
    output logic             done,
    output logic [LEN_W-1:0] len_pc,
    output logic [CNT_W-1:0] used
);
    localparam logic [LEN_W-1:0] MAXV = LEN_W'(CHAN_MAX);

    split_phase_e     phase;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] tot_q;
    logic [LEN_W:0]   acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    logic [LEN_W:0]   acc_n;
    logic [CNT_W-1:0] cnt_n;

    assign acc_n = acc_q + {1'b0, len_q};
    assign cnt_n = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= SP_IDLE;
            len_q  <= '0;
            tot_q  <= '0;
            acc_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase)
                SP_IDLE: begin
                    if (start) begin
                        len_q <= total;
                        tot_q <= total;
                        acc_q <= '0;
                        cnt_q <= '0;
                        phase <= SP_HALVE;
                    end
                end
                SP_HALVE: begin
                    if (len_q > MAXV) len_q <= len_q >> 1;
                    else              phase <= SP_ALLOC;
                end
                SP_ALLOC: begin
                    acc_q <= acc_n;
                    cnt_q <= cnt_n;
                    if (acc_n >= {1'b0, tot_q} || cnt_n == CNT_W'(NCH)) begin
                        done_q <= 1'b1;
                        phase  <= SP_IDLE;
                    end
                end
                default: phase <= SP_IDLE;
            endcase
        end
    end

    assign done   = done_q;
    assign len_pc = len_q;
    assign used   = cnt_q;
endmodule

// File: rtl/fbsc_done_track.sv
module fbsc_done_track #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] clr_mask,
    input  logic [NCH-1:0] done_in,
    output logic           all_done
);
    logic [NCH-1:0] flags;
    logic [NCH-1:0] merged;

    assign merged   = flags | done_in;
    assign all_done = &merged;

    always_ff @(posedge clk) begin
        if (rst) flags <= '1;
        else     flags <= merged & ~clr_mask;
    end
endmodule

// File: rtl/fbsc_loopcalc.sv
module fbsc_loopcalc
    import fbsc_pkg::*;
#(
    parameter int LEN_W      = 32,
    parameter int BURST_LOG2 = 5
) (
    input  logic [LEN_W-1:0] len,
    output logic [8:0]       outer,
    output logic [8:0]       inner
);
    logic [LEN_W-1:0] bursts;
    loop_cnt_t        lc;

    assign bursts = len >> BURST_LOG2;
    assign lc     = split_loops(32'(bursts));
    assign outer  = lc.outer;
    assign inner  = lc.inner;
endmodule

// File: rtl/fb_swap_copier.sv
module fb_swap_copier
    import fbsc_pkg::*;
#(
    parameter int     ADDR_W      = 32,
    parameter int     LEN_W       = 32,
    parameter int     NCH         = 4,
    parameter int     BURST_BYTES = 32,
    parameter longint FB_BASE     = 64'h0200_0000,
    parameter longint FRAME_BYTES = 1843200,
    localparam int     BURST_LOG2 = $clog2(BURST_BYTES),
    localparam longint CHAN_MAX   = longint'(BURST_BYTES) * 65536,
    localparam longint TOTAL_MAX  = CHAN_MAX * NCH,
    localparam int     CNT_W      = $clog2(NCH + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_src,
    input  logic [LEN_W-1:0]           req_len,
    input  logic [NCH-1:0]             ch_done,
    output logic                       busy,
    output logic                       req_err,
    output logic [NCH-1:0]             ch_start,
    output logic [NCH-1:0][ADDR_W-1:0] ch_dst,
    output logic [NCH-1:0][ADDR_W-1:0] ch_src,
    output logic [NCH-1:0][LEN_W-1:0]  ch_len,
    output logic [NCH-1:0][8:0]        ch_outer,
    output logic [NCH-1:0][8:0]        ch_inner,
    output logic                       park_idx,
    output logic                       swap_strobe
);
    localparam logic [ADDR_W-1:0] BUF0 = ADDR_W'(FB_BASE);
    localparam logic [ADDR_W-1:0] BUF1 = ADDR_W'(FB_BASE + FRAME_BYTES);

    ctl_state_e        state;
    logic              bad_len;
    logic              split_go;
    logic              split_done;
    logic [LEN_W-1:0]  len_pc;
    logic [CNT_W-1:0]  used;
    logic [ADDR_W-1:0] src_base_q;
    logic [ADDR_W-1:0] dst_base_q;
    logic [NCH-1:0]    use_mask;
    logic [NCH-1:0]    clr_mask;
    logic              all_done;
    logic              err_q;
    logic              swap_q;
    logic              park_q;

    assign bad_len  = req_len[LEN_W-1] || (64'(req_len) > 64'(TOTAL_MAX));
    assign split_go = (state == ST_IDLE) && req_valid && !bad_len;
    assign clr_mask = (state == ST_ISSUE) ? use_mask : '0;

    fbsc_splitter #(
        .LEN_W   (LEN_W),
        .NCH     (NCH),
        .CHAN_MAX(CHAN_MAX)
    ) u_split (
        .clk   (clk),
        .rst   (rst),
        .start (split_go),
        .total (req_len),
        .done  (split_done),
        .len_pc(len_pc),
        .used  (used)
    );

    fbsc_done_track #(.NCH(NCH)) u_track (
        .clk     (clk),
        .rst     (rst),
        .clr_mask(clr_mask),
        .done_in (ch_done),
        .all_done(all_done)
    );

    // Control sequence: accept, plan, issue, wait for completion
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            src_base_q <= '0;
            dst_base_q <= '0;
            err_q      <= 1'b0;
            swap_q     <= 1'b0;
            park_q     <= 1'b0;
        end else begin
            err_q  <= 1'b0;
            swap_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (bad_len) begin
                            err_q <= 1'b1;
                        end else begin
                            src_base_q <= req_src;
                            dst_base_q <= park_q ? BUF0 : BUF1;
                            state      <= ST_PLAN;
                        end
                    end
                end
                ST_PLAN:  if (split_done) state <= ST_ISSUE;
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (all_done) begin
                        park_q <= ~park_q;
                        swap_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_chan
            logic [ADDR_W-1:0] dst_q;
            logic [ADDR_W-1:0] src_q;
            logic [LEN_W-1:0]  len_q;
            logic              start_q;
            logic [LEN_W-1:0]  offs;

            assign use_mask[gi] = (CNT_W'(gi) < used);
            assign offs         = LEN_W'(gi) * len_pc;

            always_ff @(posedge clk) begin
                if (rst) begin
                    dst_q   <= '0;
                    src_q   <= '0;
                    len_q   <= '0;
                    start_q <= 1'b0;
                end else begin
                    start_q <= 1'b0;
                    if (state == ST_ISSUE) begin
                        start_q <= use_mask[gi];
                        if (use_mask[gi]) begin
                            dst_q <= dst_base_q + ADDR_W'(offs);
                            src_q <= src_base_q + ADDR_W'(offs);
                            len_q <= len_pc;
                        end else begin
                            dst_q <= '0;
                            src_q <= '0;
                            len_q <= '0;
                        end
                    end
                end
            end

            fbsc_loopcalc #(
                .LEN_W     (LEN_W),
                .BURST_LOG2(BURST_LOG2)
            ) u_loop (
                .len  (len_q),
                .outer(ch_outer[gi]),
                .inner(ch_inner[gi])
            );

            assign ch_dst[gi]   = dst_q;
            assign ch_src[gi]   = src_q;
            assign ch_len[gi]   = len_q;
            assign ch_start[gi] = start_q;
        end
    endgenerate

    assign busy        = (state != ST_IDLE);
    assign req_err     = err_q;
    assign swap_strobe = swap_q;
    assign park_idx    = park_q;
endmodule

// File: rtl/fbsc_checker.sv
module fbsc_checker #(
    parameter int     ADDR_W      = 32,
    parameter int     LEN_W       = 32,
    parameter int     NCH         = 4,
    parameter longint CHAN_MAX    = 2097152,
    parameter longint FB_BASE     = 64'h0200_0000,
    parameter longint FRAME_BYTES = 1843200
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       busy,
    input logic                       req_err,
    input logic [NCH-1:0]             ch_start,
    input logic [NCH-1:0]             ch_done,
    input logic [NCH-1:0][ADDR_W-1:0] ch_dst,
    input logic [NCH-1:0][LEN_W-1:0]  ch_len,
    input logic                       park_idx,
    input logic                       swap_strobe
);
    // R8: the swap pulse lasts one cycle
    p_swap_single_r8: assert property (@(posedge clk) disable iff (rst)
        swap_strobe |=> !swap_strobe);

    // R8: the parked index only moves together with the swap pulse
    p_park_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !swap_strobe |-> $stable(park_idx));

    // R7: engines are started only while a copy is in flight
    p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (|ch_start) |-> busy);

    // R6: a rejection never starts an engine
    p_err_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (ch_start == '0) && !busy);

    // R4: claimed engines form a prefix starting at engine 0
    p_prefix_r4: assert property (@(posedge clk) disable iff (rst)
        (|ch_start) |-> ch_start[0] && (((ch_start + NCH'(1)) & ch_start) == '0));

    // R3: the share handed out fits one engine
    p_share_fits_r3: assert property (@(posedge clk) disable iff (rst)
        (|ch_start) |-> (64'(ch_len[0]) <= 64'(CHAN_MAX)));

    // R2: the destination is the buffer not on screen
    p_dst_other_r2: assert property (@(posedge clk) disable iff (rst)
        (|ch_start) |-> (ch_dst[0] == (park_idx ? ADDR_W'(FB_BASE)
                                                : ADDR_W'(FB_BASE + FRAME_BYTES))));

    // R10: done pulses while idle cause no swap
    p_idle_done_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && (|ch_done)) |=> !swap_strobe);
endmodule

bind fb_swap_copier fbsc_checker #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .NCH        (NCH),
    .CHAN_MAX   (CHAN_MAX),
    .FB_BASE    (FB_BASE),
    .FRAME_BYTES(FRAME_BYTES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .req_err    (req_err),
    .ch_start   (ch_start),
    .ch_done    (ch_done),
    .ch_dst     (ch_dst),
    .ch_len     (ch_len),
    .park_idx   (park_idx),
    .swap_strobe(swap_strobe)
);

// File: tb/sim_fb_swap_copier.sv
module sim_fb_swap_copier;
    localparam int     ADDR_W   = 32;
    localparam int     LEN_W    = 32;
    localparam int     NCH      = 4;
    localparam longint MAXC     = 32 * 65536;
    localparam longint FBB      = 64'h0200_0000;
    localparam longint FRM      = 1843200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_src = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [NCH-1:0]    ch_done = '0;
    logic busy, req_err, park_idx, swap_strobe;
    logic [NCH-1:0] ch_start;
    logic [NCH-1:0][ADDR_W-1:0] ch_dst, ch_src;
    logic [NCH-1:0][LEN_W-1:0]  ch_len;
    logic [NCH-1:0][8:0] ch_outer, ch_inner;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic park_exp = 1'b0;

    always #4 clk = ~clk;

    fb_swap_copier u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
        .req_len(req_len), .ch_done(ch_done), .busy(busy), .req_err(req_err),
        .ch_start(ch_start), .ch_dst(ch_dst), .ch_src(ch_src), .ch_len(ch_len),
        .ch_outer(ch_outer), .ch_inner(ch_inner), .park_idx(park_idx),
        .swap_strobe(swap_strobe)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint share(input longint t);
        longint l = t;
        while (l > MAXC) l = l / 2;
        return l;
    endfunction

    function automatic int claimed(input longint t);
        longint l = share(t);
        longint acc = 0;
        int n = 0;
        do begin
            n++;
            acc += l;
        end while (acc < t && n < NCH);
        return n;
    endfunction

    task automatic run_copy(input longint total);
        longint l;
        int n;
        int rot;
        int seen;
        longint dbase;
        logic [ADDR_W-1:0] src;
        l = share(total);
        n = claimed(total);
        src = $urandom & 32'h0FFF_FFFC;
        dbase = park_exp ? FBB : FBB + FRM;
        @(negedge clk);
        req_valid = 1'b1; req_src = src; req_len = LEN_W'(total);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_err == 1'b0, "R6 no error on legal length", req_err, 0);
        seen = 0;
        for (int w = 0; w < 200 && seen == 0; w++) begin
            if (ch_start != '0) seen = 1;
            else @(negedge clk);
        end
        chk(seen == 1, "R4 start seen", seen, 1);
        chk(ch_start == NCH'((1 << n) - 1), "R4 claimed mask", ch_start, (1 << n) - 1);
        chk(busy == 1'b1, "R7 busy during copy", busy, 1);
        for (int i = 0; i < NCH; i++) begin
            longint b;
            if (i < n) begin
                b = l / 32;
                chk(ch_len[i] == LEN_W'(l), "R3 share length", ch_len[i], l);
                chk(ch_dst[i] == ADDR_W'(dbase + i * l), "R2 R5 destination", ch_dst[i], dbase + i * l);
                chk(ch_src[i] == ADDR_W'(src + i * l), "R5 source", ch_src[i], src + i * l);
                if (b > 256) begin
                    chk(ch_outer[i] == 9'(b / 256), "R9 outer", ch_outer[i], b / 256);
                    chk(ch_inner[i] == 9'(b % 256), "R9 residue", ch_inner[i], b % 256);
                end else begin
                    chk(ch_outer[i] == 9'd0, "R9 outer zero", ch_outer[i], 0);
                    chk(ch_inner[i] == 9'(b), "R9 inner", ch_inner[i], b);
                end
            end else begin
                chk(ch_len[i] == '0, "R5 unclaimed length", ch_len[i], 0);
            end
        end
        // R7: request while outstanding is dropped
        @(negedge clk);
        req_valid = 1'b1; req_len = 32'd64;
        @(negedge clk);
        req_valid = 1'b0;
        for (int w = 0; w < 3; w++) begin
            chk(ch_start == '0 && req_err == 1'b0, "R7 busy request ignored", ch_start, 0);
            @(negedge clk);
        end
        // R10: stray completion on an unclaimed engine
        if (n < NCH) begin
            ch_done = NCH'(1) << (NCH - 1);
            @(negedge clk);
            ch_done = '0;
            @(negedge clk);
            chk(park_idx == park_exp && busy, "R10 unclaimed done ignored", park_idx, park_exp);
        end
        rot = int'($urandom % n);
        for (int k = 0; k < n; k++) begin
            ch_done = NCH'(1) << ((k + rot) % n);
            @(negedge clk);
            ch_done = '0;
            if (k < n - 1) begin
                chk(park_idx == park_exp && !swap_strobe && busy, "R8 no early swap", park_idx, park_exp);
                repeat ($urandom % 3) @(negedge clk);
            end else begin
                park_exp = ~park_exp;
                chk(park_idx == park_exp, "R8 park toggles", park_idx, park_exp);
                chk(swap_strobe == 1'b1, "R8 swap pulse", swap_strobe, 1);
                chk(busy == 1'b0, "R7 busy drops", busy, 0);
            end
        end
        @(negedge clk);
        chk(swap_strobe == 1'b0, "R8 swap single cycle", swap_strobe, 0);
    endtask

    task automatic reject(input logic [LEN_W-1:0] len);
        @(negedge clk);
        req_valid = 1'b1; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_err == 1'b1, "R6 error pulse", req_err, 1);
        @(negedge clk);
        chk(req_err == 1'b0, "R6 error one cycle", req_err, 0);
        for (int w = 0; w < 8; w++) begin
            chk(ch_start == '0 && !busy, "R6 nothing started", ch_start, 0);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(park_idx == 1'b0, "R1 park reset", park_idx, 0);
        chk(!busy && !req_err && !swap_strobe && ch_start == '0, "R1 outputs idle", busy, 0);
        ch_done = '1;
        @(negedge clk);
        ch_done = '0;
        @(negedge clk);
        chk(park_idx == 1'b0 && !swap_strobe, "R10 idle done ignored", park_idx, 0);
        run_copy(FRM);
        run_copy(MAXC);
        run_copy(MAXC + 1);
        run_copy(3 * MAXC);
        run_copy(4 * MAXC);
        run_copy(5);
        reject(LEN_W'(4 * MAXC + 1));
        reject(32'h8000_0010);
        for (int r = 0; r < 20; r++) run_copy(longint'($urandom % (4 * MAXC + 1)));
        finish_run();
    end
endmodule